// File: doc/BRIEF.md
# Cascadable Wiper Counter

This block holds the position registers of a bank of digital potentiometers and turns each one into a one-hot select for that pot's tap switches. Each register byte has three fields. The low field is a tap position, from 00h at the low terminal to 3Fh at the high terminal. One bit turns the wiper off. The top bit links the pot to the next higher-numbered pot. A host writes whole register bytes through a load port. It can also issue single-step requests that move a chosen wiper one tap up or down.

When link bits join adjacent pots into a chain, a step request treats the chain as one long counter. When the active wiper runs off the end of its array, it turns itself off and turns on its neighbour. The neighbour starts one tap in from its own near end, so the tap the two arrays share counts only once. Chains of two, three or four arrays therefore give 127, 190 or 253 distinct positions. A step may be aimed at any pot of a chain; it always moves the wiper that is currently on.

Top module: `wiper_chain_counter`

## Requirements
- R1: After a synchronous reset every register byte reads 00h and each pot drives select line 0 only.
- R2: A register byte has bit 7 = link to next higher pot, bit 6 = wiper off, bits 5:0 = position. A load writes the full byte of the chosen pot at the next edge. A load takes priority over a step in the same cycle, and the step is then dropped.
- R3: An enabled pot drives exactly one select line, the one whose index equals its position. Pot i owns bits i*64 to i*64+63 of the select bus. The select changes on the same edge as the register.
- R4: A pot whose off bit is set drives all of its select lines low.
- R5: A step on an enabled pot below the boundary moves its position by +1 (up) or -1 (down), visible one cycle after the request.
- R6: A standalone pot, and the outermost pots of a chain, saturate at 3Fh going up and at 00h going down. The link bit of the highest-numbered pot has no effect.
- R7: Stepping up from 3Fh in a chained lower pot sets that pot's off bit and keeps its position. The next higher pot is then switched on at position 01h.
- R8: Stepping down from 00h in a chained higher pot sets that pot's off bit and keeps its position. The next lower pot is then switched on at position 3Eh.
- R9: A step aimed at a pot that is off is applied to the enabled pot of the same chain. If no pot of that chain is enabled, the step changes nothing.
- R10: A chain of four pots covers 253 positions: 252 up steps take it from the bottom of pot 0 to the top of pot 3, and a further step changes nothing.
- R11: With no load and no step, all register bytes and selects hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write ld_val into pot ld_idx |
| ld_idx | input | IDX_W | Pot written by a load |
| ld_val | input | 8 | Register byte to load |
| step_en | input | 1 | One-cycle step request |
| step_up | input | 1 | 1 = toward high terminal, 0 = toward low terminal |
| step_idx | input | IDX_W | Pot the step is aimed at |
| wreg_o | output | NUM_POTS*8 | Register bytes, pot i at bits i*8+7 to i*8 |
| sel_o | output | NUM_POTS*64 | One-hot tap selects, pot i at bits i*64+63 to i*64 |

## Verification
A wrong chain boundary or a wrong choice of active pot shows up at the ports on the edge after the faulty step. It appears as a register byte with the wrong off bit, or as two enabled pots in one chain, and it corrupts the one-hot selects from that edge on. An off-by-one in the handover position is invisible within a single array. It shows up only as a total of other than 253 positions across a full four-pot sweep, so the bench walks the whole chain both ways. Saturation faults show up one cycle after a step at an end, as a wrapped position.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int POS_W   = 6;
  localparam int REG_W   = 8;
  localparam int TAPS    = 1 << POS_W;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  typedef struct packed {
    logic             link;  // chained to next higher pot
    logic             off;   // wiper disconnected
    logic [POS_W-1:0] pos;   // tap position
  } wiper_t;
endpackage

// File: rtl/wpc_chain_find.sv
module wpc_chain_find #(
  parameter int NUM_POTS = 4,
  localparam int IDX_W = $clog2(NUM_POTS)
) (
  input  logic [NUM_POTS-2:0] link,
  input  logic [NUM_POTS-1:0] off,
  input  logic [IDX_W-1:0]    tgt,
  output logic [IDX_W-1:0]    lo,
  output logic [IDX_W-1:0]    hi,
  output logic [IDX_W-1:0]    act,
  output logic                found
);
  // lowest pot of the chain holding tgt
  always_comb begin
    lo = '0;
    for (int i = 0; i < NUM_POTS-1; i++)
      if (i < int'(tgt) && !link[i]) lo = IDX_W'(i + 1);
  end

  // highest pot of the chain holding tgt
  always_comb begin
    hi = IDX_W'(NUM_POTS - 1);
    for (int i = NUM_POTS-2; i >= 0; i--)
      if (i >= int'(tgt) && !link[i]) hi = IDX_W'(i);
  end

  // pot that actually moves: tgt if enabled, else lowest enabled in chain
  always_comb begin
    found = 1'b0;
    act   = tgt;
    if (!off[tgt]) begin
      found = 1'b1;
    end else begin
      for (int i = 0; i < NUM_POTS; i++)
        if (!found && i >= int'(lo) && i <= int'(hi) && !off[i]) begin
          act   = IDX_W'(i);
          found = 1'b1;
        end
    end
  end

  always_comb begin
    // R9
    chain_bounds_chk: assert (lo <= tgt && tgt <= hi);
  end
endmodule

// File: rtl/wpc_step_engine.sv
module wpc_step_engine
  import wpc_pkg::*;
#(
  parameter int NUM_POTS = 4,
  localparam int IDX_W = $clog2(NUM_POTS)
) (
  input  wiper_t [NUM_POTS-1:0] cur,
  input  logic   [IDX_W-1:0]    act,
  input  logic   [IDX_W-1:0]    lo,
  input  logic   [IDX_W-1:0]    hi,
  input  logic                  up,
  output wiper_t [NUM_POTS-1:0] nxt
);
  localparam logic [POS_W-1:0] POS_ONE   = POS_W'(1);
  localparam logic [POS_W-1:0] POS_INNER = POS_MAX - POS_W'(1);

  wiper_t a;
  assign a = cur[act];

  always_comb begin
    nxt = cur;
    if (up) begin
      if (a.pos != POS_MAX) begin
        nxt[act].pos = a.pos + POS_ONE;
      end else if (act != hi) begin
        nxt[act].off              = 1'b1;
        nxt[act + IDX_W'(1)].off  = 1'b0;
        nxt[act + IDX_W'(1)].pos  = POS_ONE;
      end
    end else begin
      if (a.pos != '0) begin
        nxt[act].pos = a.pos - POS_ONE;
      end else if (act != lo) begin
        nxt[act].off              = 1'b1;
        nxt[act - IDX_W'(1)].off  = 1'b0;
        nxt[act - IDX_W'(1)].pos  = POS_INNER;
      end
    end
  end
endmodule

// File: rtl/wpc_tap_decode.sv
module wpc_tap_decode
  import wpc_pkg::*;
#(
  parameter int NUM_POTS = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_POTS-1:0]               off_n,
  input  logic [NUM_POTS-1:0][POS_W-1:0]    pos_n,
  output logic [NUM_POTS*TAPS-1:0]          sel
);
  for (genvar g = 0; g < NUM_POTS; g++) begin : g_pot
    logic [TAPS-1:0] sel_q;
    always_ff @(posedge clk) begin
      if (rst)           sel_q <= TAPS'(1);
      else if (off_n[g]) sel_q <= '0;
      else               sel_q <= TAPS'(1) << pos_n[g];
    end
    assign sel[g*TAPS +: TAPS] = sel_q;

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_q));
  end
endmodule

// File: rtl/wiper_chain_counter.sv
module wiper_chain_counter
  import wpc_pkg::*;
#(
  parameter int NUM_POTS = 4,
  localparam int IDX_W = $clog2(NUM_POTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [IDX_W-1:0]           ld_idx,
  input  logic [REG_W-1:0]           ld_val,
  input  logic                       step_en,
  input  logic                       step_up,
  input  logic [IDX_W-1:0]           step_idx,
  output logic [NUM_POTS*REG_W-1:0]  wreg_o,
  output logic [NUM_POTS*TAPS-1:0]   sel_o
);
  wiper_t [NUM_POTS-1:0] wreg_q, nxt_w, eng_nxt;
  logic   [NUM_POTS-2:0] link_v;
  logic   [NUM_POTS-1:0] off_v, off_n;
  logic   [NUM_POTS-1:0][POS_W-1:0] pos_n;
  logic   [IDX_W-1:0]    lo, hi, act;
  logic                  found;

  always_comb begin
    for (int i = 0; i < NUM_POTS; i++) begin
      off_v[i] = wreg_q[i].off;
      off_n[i] = nxt_w[i].off;
      pos_n[i] = nxt_w[i].pos;
    end
    for (int i = 0; i < NUM_POTS-1; i++) link_v[i] = wreg_q[i].link;
  end

  wpc_chain_find #(.NUM_POTS(NUM_POTS)) u_find (
    .link(link_v), .off(off_v), .tgt(step_idx),
    .lo(lo), .hi(hi), .act(act), .found(found)
  );

  wpc_step_engine #(.NUM_POTS(NUM_POTS)) u_eng (
    .cur(wreg_q), .act(act), .lo(lo), .hi(hi), .up(step_up), .nxt(eng_nxt)
  );

  always_comb begin
    nxt_w = wreg_q;
    if (ld_en)                 nxt_w[ld_idx] = ld_val;
    else if (step_en && found) nxt_w = eng_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) wreg_q <= '0;
    else     wreg_q <= nxt_w;
  end

  wpc_tap_decode #(.NUM_POTS(NUM_POTS)) u_dec (
    .clk(clk), .rst(rst), .off_n(off_n), .pos_n(pos_n), .sel(sel_o)
  );

  assign wreg_o = wreg_q;

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_en && !step_en |=> $stable(wreg_q));

  // R7
  enabled_count_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $countones(off_v) == $past($countones(off_v)));

  for (genvar g = 0; g < NUM_POTS; g++) begin : g_chk
    // R4
    off_sel_chk: assert property (@(posedge clk) disable iff (rst)
      wreg_q[g].off |-> sel_o[g*TAPS +: TAPS] == '0);
  end
endmodule

// File: tb/wiper_chain_counter_tb.sv
`timescale 1ns/1ps
module wiper_chain_counter_tb;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_en = 1'b0, step_en = 1'b0, step_up = 1'b0;
  logic [IW-1:0] ld_idx = '0, step_idx = '0;
  logic [7:0] ld_val = '0;
  logic [N*8-1:0]  wreg_o;
  logic [N*64-1:0] sel_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wiper_chain_counter #(.NUM_POTS(N)) u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
    .step_en(step_en), .step_up(step_up), .step_idx(step_idx),
    .wreg_o(wreg_o), .sel_o(sel_o)
  );

  function automatic logic [7:0] rg(int i);
    return wreg_o[i*8 +: 8];
  endfunction

  task automatic chk_reg(int i, logic [7:0] exp, string tag);
    checks++;
    if (rg(i) !== exp) begin
      fails++;
      $display("FAIL %s pot%0d reg actual=%h expected=%h", tag, i, rg(i), exp);
    end
  endtask

  task automatic chk_sel(int i, string tag);
    logic [63:0] exp;
    exp = rg(i)[6] ? 64'd0 : (64'd1 << rg(i)[5:0]);
    checks++;
    if (sel_o[i*64 +: 64] !== exp) begin
      fails++;
      $display("FAIL %s pot%0d sel actual=%h expected=%h", tag, i, sel_o[i*64 +: 64], exp);
    end
  endtask

  task automatic load(int i, logic [7:0] v);
    @(negedge clk); ld_en = 1'b1; ld_idx = IW'(i); ld_val = v;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic step(int i, bit up);
    @(negedge clk); step_en = 1'b1; step_idx = IW'(i); step_up = up;
    @(negedge clk); step_en = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < N; i++) begin chk_reg(i, 8'h00, "R1"); chk_sel(i, "R1"); end
    checks++;
    if (sel_o[0] !== 1'b1) begin fails++; $display("FAIL R1 sel0 actual=%b expected=1", sel_o[0]); end
  endtask

  task automatic t_load_decode;
    load(1, 8'h25); chk_reg(1, 8'h25, "R2"); chk_sel(1, "R3");
    checks++;
    if (sel_o[64+37] !== 1'b1) begin fails++; $display("FAIL R3 line37 actual=0 expected=1"); end
    load(2, 8'h5A); chk_reg(2, 8'h5A, "R2"); chk_sel(2, "R4");
    checks++;
    if (sel_o[128 +: 64] !== 64'd0) begin fails++; $display("FAIL R4 sel actual=%h expected=0", sel_o[128 +: 64]); end
    // load wins over step in the same cycle
    @(negedge clk); ld_en = 1'b1; ld_idx = 2'd1; ld_val = 8'h10;
    step_en = 1'b1; step_idx = 2'd1; step_up = 1'b1;
    @(negedge clk); ld_en = 1'b0; step_en = 1'b0;
    chk_reg(1, 8'h10, "R2");
  endtask

  task automatic t_step;
    load(0, 8'h0A);
    step(0, 1'b1); chk_reg(0, 8'h0B, "R5"); chk_sel(0, "R5");
    step(0, 1'b0); step(0, 1'b0); chk_reg(0, 8'h09, "R5");
    repeat (3) @(negedge clk);
    chk_reg(0, 8'h09, "R11"); chk_sel(0, "R11");
  endtask

  task automatic t_saturate;
    load(1, 8'h00);
    load(0, 8'h3F); step(0, 1'b1); chk_reg(0, 8'h3F, "R6");
    chk_reg(1, 8'h00, "R6");
    load(0, 8'h00); step(0, 1'b0); chk_reg(0, 8'h00, "R6");
    load(3, 8'hBF); step(3, 1'b1); chk_reg(3, 8'hBF, "R6");
  endtask

  task automatic t_handover;
    load(0, 8'hBF); load(1, 8'h40);
    step(0, 1'b1); chk_reg(0, 8'hFF, "R7"); chk_reg(1, 8'h01, "R7");
    chk_sel(0, "R7"); chk_sel(1, "R7");
    step(1, 1'b0); chk_reg(1, 8'h00, "R8");
    step(1, 1'b0); chk_reg(1, 8'h40, "R8"); chk_reg(0, 8'hBE, "R8");
    chk_sel(0, "R8");
    step(1, 1'b1); chk_reg(0, 8'hBF, "R9"); chk_reg(1, 8'h40, "R9");
    load(0, 8'hC5); step(1, 1'b1);
    chk_reg(0, 8'hC5, "R9"); chk_reg(1, 8'h40, "R9");
  endtask

  task automatic t_full_chain;
    load(0, 8'h80); load(1, 8'hC0); load(2, 8'hC0); load(3, 8'hC0);
    for (int k = 0; k < 252; k++) step(2, 1'b1);
    chk_reg(0, 8'hFF, "R10"); chk_reg(1, 8'hFF, "R10");
    chk_reg(2, 8'hFF, "R10"); chk_reg(3, 8'hBF, "R10");
    step(0, 1'b1); chk_reg(3, 8'hBF, "R10"); chk_sel(3, "R10");
    for (int k = 0; k < 252; k++) step(1, 1'b0);
    chk_reg(0, 8'h80, "R10"); chk_reg(1, 8'hC0, "R10");
    chk_reg(2, 8'hC0, "R10"); chk_reg(3, 8'hC0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_decode();
    t_step();
    t_saturate();
    t_handover();
    t_full_chain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule